// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block takes a write-only three-wire control port: a mode line, a serial clock and a serial data line. It turns that port into a set of configuration fields for an audio converter. All three pins are asynchronous to the system clock. Each pin passes through a synchroniser, and bits are taken on rising edges of the serial clock as seen through that synchroniser. Bytes arrive least significant bit first. A byte counts only once all eight of its bits have arrived.

A byte received while the mode line is low is an address. Its upper six bits must match the device address, or the receiver deselects itself. Its lower two bits pick one of two register banks. Bytes received while the mode line is high are data. The address selection stays in force for any number of them, and the top two bits of each data byte choose the register it writes. The clock ratio, data format, DC filter enable, volume, de-emphasis, mute and power enables are decoded continuously onto output pins.

The control port has no stream interface, so every pin here is a plain level with no handshake. The serial clock must run no faster than one cycle per 500 ns, with each phase at least 250 ns long. The system clock must be fast enough to see every phase through the synchroniser.

Top module: `ctl3w_rx`

## Requirements
- R1: An address byte sent with the mode line low selects the receiver only when its bits 7:2 equal the device address (default 6'b000101, bit 7 as MSB). After any other address, data bytes change no output.
- R2: Address bits 1:0 pick the bank: 2'b00 selects the data bank and 2'b10 selects the status bank. After 2'b01 or 2'b11, data bytes change no output.
- R3: The device and bank selection stays in force across any number of consecutive data bytes, until the next address byte arrives.
- R4: Bits are taken LSB first on rising serial clock edges, and a byte takes effect only after its eighth bit. A change of the mode line discards any partly received byte and restarts the bit count.
- R5: In the status bank, a byte whose bits 7:6 are 2'b00 sets clk_ratio from bits 5:4 (00=512fs, 01=384fs, 10=256fs), fmt_code from bits 3:1 and dc_filt_en from bit 0. A status byte whose bits 7:6 are anything else is ignored.
- R6: In the data bank, a byte with bits 7:6 = 2'b00 sets volume from bits 5:0.
- R7: In the data bank, a byte with bits 7:6 = 2'b10 sets deemph from bits 4:3 and mute from bit 2.
- R8: In the data bank, a byte with bits 7:6 = 2'b11 sets adc_en from bit 1 and dac_en from bit 0. A byte with bits 7:6 = 2'b01 changes no output.
- R9: A synchronous reset clears every output field to zero and deselects the receiver.
- R10: Output fields change only in the cycle after a byte is committed. In every other cycle they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| mode_pin | input | 1 | Mode line: low for an address byte, high for data bytes |
| sclk_pin | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdat_pin | input | 1 | Serial data, LSB first |
| clk_ratio | output | 2 | System clock ratio code |
| fmt_code | output | 3 | Serial audio format code |
| dc_filt_en | output | 1 | DC cancellation filter enable |
| volume | output | 6 | Attenuation code |
| deemph | output | 2 | De-emphasis selection |
| mute | output | 1 | Playback mute |
| adc_en | output | 1 | ADC power enable |
| dac_en | output | 1 | DAC power enable |

## Verification
The assertions check three things on every cycle. The output fields hold steady unless a byte has just been committed. A committed byte always follows a detected serial clock edge. No byte can commit right after a mode change. They also check that a deselected receiver, an ignored status byte or a data byte never moves the selection or the fields, and that reset clears everything. Only the bench scenarios can show the rest: the serial-to-field mapping, LSB-first bit order, device address matching, both unused bank codes, and a partial byte being dropped when the mode line toggles. These depend on multi-byte sequences that compare against values worked out from the requirements.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [1:0] {
    BANK_DATA   = 2'b00,
    BANK_RSV_A  = 2'b01,
    BANK_STATUS = 2'b10,
    BANK_RSV_B  = 2'b11
  } bank_e;

  typedef enum logic [1:0] {
    DSEL_VOL    = 2'b00,
    DSEL_NONE   = 2'b01,
    DSEL_DEEMPH = 2'b10,
    DSEL_PWR    = 2'b11
  } dsel_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic       dc_en;
  } status_t;

  typedef struct packed {
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
    logic       adc_en;
    logic       dac_en;
  } data_t;
endpackage

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg[LAST];
endmodule

// File: rtl/ctl3w_shift.sv
`timescale 1ns/1ps
module ctl3w_shift
  import ctl3w_pkg::*;
#(
  parameter int unsigned BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_s,
  input  logic            sclk_s,
  input  logic            sdat_s,
  output logic            byte_vld,
  output logic [BITS-1:0] byte_q,
  output logic            byte_is_data
);
  localparam int unsigned CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic            sclk_q;
  logic            mode_q;
  logic [CW-1:0]   cnt;
  logic [BITS-2:0] sr;
  logic            rise;
  logic            mode_chg;

  assign rise     = sclk_s & ~sclk_q;
  assign mode_chg = mode_s ^ mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q       <= 1'b0;
      mode_q       <= 1'b0;
      cnt          <= '0;
      sr           <= '0;
      byte_vld     <= 1'b0;
      byte_q       <= '0;
      byte_is_data <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      mode_q   <= mode_s;
      byte_vld <= 1'b0;
      if (mode_chg) begin
        cnt <= '0;
      end else if (rise) begin
        sr <= {sdat_s, sr[BITS-2:1]};
        if (cnt == LAST_BIT) begin
          cnt          <= '0;
          byte_vld     <= 1'b1;
          byte_q       <= {sdat_s, sr};
          byte_is_data <= mode_s;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a commit is always caused by a serial clock edge one cycle earlier
  p_commit_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(sclk_s && !sclk_q));

  // R4: a mode change never lets a byte through in the next cycle
  p_mode_change_drops_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_s != mode_q) |=> !byte_vld);
endmodule

// File: rtl/ctl3w_regs.sv
`timescale 1ns/1ps
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              byte_is_data,
  output status_t           st,
  output data_t             dt
);
  logic  sel_ok;
  bank_e bank;
  dsel_e dsel;

  assign dsel = dsel_e'(byte_q[7:6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ok <= 1'b0;
      bank   <= BANK_DATA;
      st     <= '0;
      dt     <= '0;
    end else if (byte_vld) begin
      if (!byte_is_data) begin
        sel_ok <= (byte_q[7:2] == DEV_ADDR);
        bank   <= bank_e'(byte_q[1:0]);
      end else if (sel_ok) begin
        case (bank)
          BANK_DATA: begin
            case (dsel)
              DSEL_VOL:    dt.vol <= byte_q[5:0];
              DSEL_DEEMPH: begin
                dt.deemph <= byte_q[4:3];
                dt.mute   <= byte_q[2];
              end
              DSEL_PWR: begin
                dt.adc_en <= byte_q[1];
                dt.dac_en <= byte_q[0];
              end
              default: ;
            endcase
          end
          BANK_STATUS: begin
            if (byte_q[7:6] == 2'b00) begin
              st.ratio <= byte_q[5:4];
              st.fmt   <= byte_q[3:1];
              st.dc_en <= byte_q[0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: fields only move after a committed byte
  p_fields_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> ($stable(st) && $stable(dt)));

  // R1: deselected receiver never touches any field
  p_unselected_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_is_data && !sel_ok) |=> ($stable(st) && $stable(dt)));

  // R3: data bytes never alter the selection
  p_selection_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_is_data) |=> ($stable(sel_ok) && $stable(bank)));

  // R5: status bytes with nonzero top bits are dropped
  p_status_filter_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_is_data && bank == BANK_STATUS && byte_q[7:6] != 2'b00)
      |=> ($stable(st) && $stable(dt)));

  // R9: reset clears every field and the selection
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (st == '0 && dt == '0 && !sel_ok));
endmodule

// File: rtl/ctl3w_rx.sv
`timescale 1ns/1ps
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_pin,
  input  logic       sclk_pin,
  input  logic       sdat_pin,
  output logic [1:0] clk_ratio,
  output logic [2:0] fmt_code,
  output logic       dc_filt_en,
  output logic [5:0] volume,
  output logic [1:0] deemph,
  output logic       mute,
  output logic       adc_en,
  output logic       dac_en
);
  localparam int unsigned PIN_N = 3;

  logic [PIN_N-1:0]  pins_s;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_is_data;
  status_t           st;
  data_t             dt;

  ctl3w_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({mode_pin, sclk_pin, sdat_pin}),
    .dout (pins_s)
  );

  ctl3w_shift #(.BITS(BYTE_W)) u_shift (
    .clk          (clk),
    .rst          (rst),
    .mode_s       (pins_s[2]),
    .sclk_s       (pins_s[1]),
    .sdat_s       (pins_s[0]),
    .byte_vld     (byte_vld),
    .byte_q       (byte_q),
    .byte_is_data (byte_is_data)
  );

  ctl3w_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .byte_vld     (byte_vld),
    .byte_q       (byte_q),
    .byte_is_data (byte_is_data),
    .st           (st),
    .dt           (dt)
  );

  assign clk_ratio  = st.ratio;
  assign fmt_code   = st.fmt;
  assign dc_filt_en = st.dc_en;
  assign volume     = dt.vol;
  assign deemph     = dt.deemph;
  assign mute       = dt.mute;
  assign adc_en     = dt.adc_en;
  assign dac_en     = dt.dac_en;
endmodule

// File: tb/test_ctl3w_rx.sv
`timescale 1ns/1ps
module test_ctl3w_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_pin = 1'b0;
  logic       sclk_pin = 1'b0;
  logic       sdat_pin = 1'b0;
  logic [1:0] clk_ratio;
  logic [2:0] fmt_code;
  logic       dc_filt_en;
  logic [5:0] volume;
  logic [1:0] deemph;
  logic       mute;
  logic       adc_en;
  logic       dac_en;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  localparam int HALF = 25;

  always #5 clk = ~clk;

  ctl3w_rx i_ctl3w_rx (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .sclk_pin(sclk_pin),
    .sdat_pin(sdat_pin), .clk_ratio(clk_ratio), .fmt_code(fmt_code),
    .dc_filt_en(dc_filt_en), .volume(volume), .deemph(deemph), .mute(mute),
    .adc_en(adc_en), .dac_en(dac_en)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic md, input logic [7:0] val, input int n);
    if (mode_pin != md) begin
      mode_pin = md;
      wait_cyc(30);
    end
    for (int i = 0; i < n; i++) begin
      sdat_pin = val[i];
      wait_cyc(HALF);
      sclk_pin = 1'b1;
      wait_cyc(HALF);
      sclk_pin = 1'b0;
    end
    wait_cyc(10);
  endtask

  task automatic send_byte(input logic md, input logic [7:0] val);
    send_bits(md, val, 8);
  endtask

  task automatic t_reset;
    check("R9 ratio", clk_ratio, 0);
    check("R9 fmt", fmt_code, 0);
    check("R9 dc", dc_filt_en, 0);
    check("R9 volume", volume, 0);
    check("R9 deemph", deemph, 0);
    check("R9 mute", mute, 0);
    check("R9 power", {adc_en, dac_en}, 0);
  endtask

  task automatic t_status;
    send_byte(1'b0, 8'h16);
    send_byte(1'b1, 8'h1B);
    check("R5 ratio", clk_ratio, 1);
    check("R5 fmt", fmt_code, 5);
    check("R5 dc", dc_filt_en, 1);
    send_byte(1'b1, 8'h26);
    check("R3 ratio second byte", clk_ratio, 2);
    check("R3 fmt second byte", fmt_code, 3);
    check("R3 dc second byte", dc_filt_en, 0);
    send_byte(1'b1, 8'h7F);
    check("R5 ignored status top bits", {clk_ratio, fmt_code, dc_filt_en}, {2'd2, 3'd3, 1'b0});
  endtask

  task automatic t_data;
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h2A);
    check("R6 volume", volume, 42);
    send_byte(1'b1, 8'h94);
    check("R7 deemph", deemph, 2);
    check("R7 mute", mute, 1);
    send_byte(1'b1, 8'hC2);
    check("R8 adc_en", adc_en, 1);
    check("R8 dac_en", dac_en, 0);
    send_byte(1'b1, 8'h7F);
    check("R8 unused selector volume", volume, 42);
    check("R8 unused selector power", {adc_en, dac_en}, 2);
    check("R8 unused selector deemph/mute", {deemph, mute}, 5);
    send_byte(1'b1, 8'hC1);
    check("R8 power swap", {adc_en, dac_en}, 1);
    check("R3 status untouched by data bank", {clk_ratio, fmt_code}, {2'd2, 3'd3});
  endtask

  task automatic t_address;
    send_byte(1'b0, 8'h18);
    send_byte(1'b1, 8'h00);
    check("R1 wrong address volume", volume, 42);
    send_byte(1'b1, 8'hC3);
    check("R1 wrong address power", {adc_en, dac_en}, 1);
    send_byte(1'b0, 8'h15);
    send_byte(1'b1, 8'h05);
    check("R2 bank 01 ignored", volume, 42);
    send_byte(1'b0, 8'h17);
    send_byte(1'b1, 8'h00);
    check("R2 bank 11 ignored", {clk_ratio, fmt_code, dc_filt_en}, {2'd2, 3'd3, 1'b0});
    check("R2 bank 11 volume", volume, 42);
  endtask

  task automatic t_partial;
    send_byte(1'b0, 8'h14);
    send_bits(1'b1, 8'h01, 4);
    check("R4 no commit before eighth bit", volume, 42);
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h0F);
    check("R4 partial byte dropped on mode change", volume, 15);
  endtask

  task automatic t_reset_again;
    wait_cyc(2);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(3);
    check("R9 volume after reset", volume, 0);
    check("R9 power after reset", {adc_en, dac_en}, 0);
    send_byte(1'b1, 8'h0F);
    check("R9 deselected after reset", volume, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    t_reset();
    t_status();
    t_data();
    t_address();
    t_partial();
    t_reset_again();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule